// File: doc/BRIEF.md
# Serial PHY Management Command Engine

This block runs single management transactions on a two-wire PHY management bus (MDC clock, bidirectional MDIO data). Software sees two 16-bit registers. The control register takes a command word: PHY address, register number and a write flag. The data register holds the value to send, or the value that came back. Writing a command while the engine is idle starts one frame. A sticky finished flag in the control register reads 1 whenever no frame is running. Software polls it before issuing a command, and again afterwards to learn when the frame has completed.

Each frame follows the common clause-22 layout. It has a run of preamble ones, then the start pattern, the opcode, the 5-bit PHY address, the 5-bit register number, a turnaround pair, and 16 data bits sent most significant bit first. MDC comes from the system clock through a parameterised divider. Outgoing bits change when MDC falls, and incoming bits are sampled when MDC rises. During a read the output enable is released for the turnaround and the data bits, so the PHY can drive the line.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset the control register reads 16'h8000 (finished set, all fields zero), the data register reads 0, and MDC and the MDIO output enable are low.
- R2: A write to the control register (reg_sel = 0) while finished is set starts a frame in the next cycle. Finished reads 0 for exactly 128*HALF_DIV cycles and then reads 1 again (default preamble of 32).
- R3: While a frame runs, MDC is low for HALF_DIV cycles and then high for HALF_DIV cycles, starting low. While idle it stays low.
- R4: The frame bit order is 32 ones, 0, 1, then the opcode (1,0 for a read and 0,1 for a write), then control bits 12:8 MSB first, then control bits 4:0 MSB first. Each bit is presented for one MDC period and changes only when MDC falls.
- R5: In a write (control bit 13 = 1), the output enable stays high for the whole frame. The turnaround is 1,0 and is followed by the data register value, MSB first.
- R6: In a read (control bit 13 = 0), the output enable is high for the first 46 bit periods and low for the last 18 (turnaround and data).
- R7: In a read, MDIO is sampled at the MDC rising edge of each of the last 16 bit periods, MSB first. The 16-bit result is loaded into the data register in the same cycle that finished returns to 1.
- R8: A control register write while a frame is running has no effect on the frame or on the control register contents.
- R9: Control readback is: bit 15 = finished, bit 13 = write flag, bits 12:8 = PHY address, bits 4:0 = register number of the last accepted command, all other bits 0. reg_sel = 1 selects the data register.
- R10: A data register write (reg_sel = 1) updates its readback at any time. A frame that is running never changes the data register, except through the read result at completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control, 1 data |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Readback of the selected register |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Output enable for the MDIO pad |
| mdio_i | input | 1 | Management data in from the pad |

## Verification
A bit counter or shift register that slips would show on the pins within one MDC period. The bench catches it because MDC, the output enable and the driven data are compared with an independent cycle count on every clock. A capture error inside the engine stays hidden until the frame ends, and then appears at once as a wrong data register value. A busy flag that clears early or late shows as a finished bit that flips in the wrong cycle. An accepted mid-frame command shows as a corrupted frame or as changed control readback.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int TAIL_BITS = 32;  // start, op, addresses, turnaround, data
  localparam int TA_BITS   = 18;  // bits released during a read
  localparam int DATA_BITS = 16;

  typedef struct packed {
    logic       wr;
    logic [4:0] phy;
    logic [4:0] regad;
  } mdio_cmd_t;

  function automatic mdio_cmd_t decode_cmd(input logic [15:0] w);
    mdio_cmd_t c;
    c.wr    = w[13];
    c.phy   = w[12:8];
    c.regad = w[4:0];
    return c;
  endfunction
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (cnt == LAST) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign rise_tick = run && (cnt == LAST) && !mdc;
  assign fall_tick = run && (cnt == LAST) && mdc;
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
#(
  parameter int PREAMBLE = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  mdio_cmd_t   cmd,
  input  logic [15:0] wdata,
  input  logic        rise_tick,
  input  logic        fall_tick,
  input  logic        mdio_i,
  output logic        busy,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        done,
  output logic [15:0] rd_data
);
  localparam int NBITS = PREAMBLE + TAIL_BITS;
  localparam int IW    = $clog2(NBITS) + 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(NBITS - 1);
  localparam logic [IW-1:0] REL_IDX  = IW'(NBITS - TA_BITS);
  localparam logic [IW-1:0] CAP_IDX  = IW'(NBITS - DATA_BITS);

  logic [NBITS-1:0] shreg;
  logic [IW-1:0]    idx;
  logic [IW-1:0]    idx_nx;
  logic             is_rd;
  logic [15:0]      capt;
  logic [NBITS-1:0] frame;

  always_comb begin
    frame = {{PREAMBLE{1'b1}}, 2'b01,
             cmd.wr ? 2'b01 : 2'b10,
             cmd.phy, cmd.regad,
             cmd.wr ? 2'b10 : 2'b11,
             cmd.wr ? wdata : 16'hFFFF};
  end

  assign idx_nx = idx + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      shreg   <= '0;
      idx     <= '0;
      is_rd   <= 1'b0;
      mdio_oe <= 1'b0;
      capt    <= '0;
    end else begin
      if (start && !busy) begin
        busy    <= 1'b1;
        shreg   <= frame;
        idx     <= '0;
        is_rd   <= !cmd.wr;
        mdio_oe <= 1'b1;
      end else if (busy && fall_tick) begin
        if (idx == LAST_IDX) begin
          busy    <= 1'b0;
          mdio_oe <= 1'b0;
        end else begin
          idx     <= idx_nx;
          shreg   <= {shreg[NBITS-2:0], 1'b1};
          mdio_oe <= !(is_rd && (idx_nx >= REL_IDX));
        end
      end
      if (busy && rise_tick && (idx >= CAP_IDX))
        capt <= {capt[14:0], mdio_i};
    end
  end

  assign mdio_o  = shreg[NBITS-1];
  assign done    = busy && fall_tick && (idx == LAST_IDX) && is_rd;
  assign rd_data = capt;
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int PREAMBLE = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  mdio_cmd_t   ctrl_q;
  logic [15:0] data_q;
  logic        busy;
  logic        start;
  logic        rise_tick;
  logic        fall_tick;
  logic        done;
  logic [15:0] rd_data;

  assign start = reg_wr && !reg_sel && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      data_q <= '0;
    end else begin
      if (start) ctrl_q <= decode_cmd(reg_wdata);
      if (reg_wr && reg_sel) data_q <= reg_wdata;
      if (done) data_q <= rd_data;
    end
  end

  assign reg_rdata = reg_sel ? data_q
                             : {!busy, 1'b0, ctrl_q.wr, ctrl_q.phy, 3'b000, ctrl_q.regad};

  mdio_clk_gen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst(rst), .run(busy),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_seq #(.PREAMBLE(PREAMBLE)) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .cmd(decode_cmd(reg_wdata)), .wdata(data_q),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
    .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done(done), .rd_data(rd_data)
  );
endmodule

// File: rtl/mdio_cmd_engine_chk.sv
module mdio_cmd_engine_chk (
  input logic        clk,
  input logic        rst,
  input logic        reg_wr,
  input logic        reg_sel,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        busy,
  input logic [10:0] ctrl_bits,
  input logic [15:0] data_bits
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !mdio_oe)); // R3
  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !reg_sel && !busy) |=> busy); // R2
  AST_CTRL_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !reg_sel && busy) |=> $stable(ctrl_bits)); // R8
  AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (busy && $rose(mdc)) |-> $stable(mdio_o)); // R4
  AST_DATA_KEEP: assert property (@(posedge clk) disable iff (rst)
    (busy && !(reg_wr && reg_sel)) |=> (!busy || $stable(data_bits))); // R10
endmodule

bind mdio_cmd_engine mdio_cmd_engine_chk u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .busy(busy),
  .ctrl_bits(ctrl_q), .data_bits(data_q)
);

// File: tb/sim_mdio_cmd_engine.sv
module sim_mdio_cmd_engine;
  localparam int HD = 2;
  localparam int FLEN = 128 * HD;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;
  bit run_done = 0;

  always #5 clk = ~clk;

  mdio_cmd_engine #(.HALF_DIV(HD), .PREAMBLE(32)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // behavioural reference: cycle count since start, frame as a bit vector
  int          mt = -1;
  bit          m_wr;
  logic [63:0] m_frame;
  logic [15:0] m_data = '0;
  logic [15:0] m_cap = '0;
  logic [15:0] m_pat = '0;

  always @(posedge clk) begin
    int ot;
    if (rst) begin
      mt = -1; m_data = '0; m_cap = '0;
    end else begin
      ot = mt;
      if (ot >= 0 && (ot % (2*HD)) == HD-1 && ot / (2*HD) >= 48)
        m_cap = {m_cap[14:0], mdio_i};
      if (reg_wr && reg_sel) m_data = reg_wdata;
      if (ot >= 0) begin
        if (ot == FLEN-1) begin
          mt = -1;
          if (!m_wr) m_data = m_cap;
        end else mt = ot + 1;
      end else if (reg_wr && !reg_sel) begin
        mt = 0;
        m_wr = reg_wdata[13];
        m_frame = {32'hFFFF_FFFF, 2'b01, m_wr ? 2'b01 : 2'b10,
                   reg_wdata[12:8], reg_wdata[4:0],
                   m_wr ? 2'b10 : 2'b11, m_wr ? m_data : 16'hFFFF};
      end
    end
  end

  always @(negedge clk) begin
    int idx;
    if (!rst) begin
      idx = (mt >= 0) ? mt / (2*HD) : 0;
      check("R3 mdc", {15'b0, mdc}, {15'b0, (mt >= 0) ? 1'b1 & ((mt / HD) % 2 == 1) : 1'b0});
      check("R5/R6 oe", {15'b0, mdio_oe},
            {15'b0, (mt >= 0) && !(!m_wr && idx >= 46)});
      if (mt >= 0 && mdio_oe)
        check("R4 mdio_o", {15'b0, mdio_o}, {15'b0, m_frame[63-idx]});
      mdio_i = (mt >= 0 && idx >= 48) ? m_pat[63-idx] : 1'b1;
    end
  end

  task automatic wr_reg(input logic sel, input logic [15:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic sel, output logic [15:0] v);
    reg_sel = sel;
    #1 v = reg_rdata;
  endtask

  // issue a command and check finished timing; returns at first idle cycle
  task automatic run_frame(input logic [15:0] cw);
    logic [15:0] v;
    wr_reg(1'b0, cw);
    repeat (FLEN-1) @(negedge clk);
    rd_reg(1'b0, v);
    check("R2 finished low at last busy cycle", {15'b0, v[15]}, 16'h0);
    @(negedge clk);
    rd_reg(1'b0, v);
    check("R2 finished after frame", {15'b0, v[15]}, 16'h1);
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rd_reg(1'b0, v); check("R1 ctrl after reset", v, 16'h8000);
    rd_reg(1'b1, v); check("R1 data after reset", v, 16'h0000);
    check("R1 mdc/oe after reset", {14'b0, mdc, mdio_oe}, 16'h0);

    // R10: data write, readback
    wr_reg(1'b1, 16'hA55A);
    rd_reg(1'b1, v); check("R10 data readback", v, 16'hA55A);

    // write frame: phy 05, reg 1A
    run_frame(16'h251A);
    rd_reg(1'b0, v); check("R9 ctrl readback write", v, 16'hA51A);
    rd_reg(1'b1, v); check("R10 data kept after write frame", v, 16'hA55A);

    // read frame with pattern 8001
    m_pat = 16'h8001;
    run_frame(16'h1F00);
    rd_reg(1'b1, v); check("R7 read data 8001", v, 16'h8001);
    rd_reg(1'b0, v); check("R9 ctrl readback read", v, 16'h9F00);

    // read with a command written mid-frame (R8)
    m_pat = 16'h3C96;
    wr_reg(1'b0, 16'h0A13);
    repeat (20) @(negedge clk);
    rd_reg(1'b0, v); check("R2 finished low while busy", v, 16'h0A13);
    wr_reg(1'b0, 16'h3FFF);
    rd_reg(1'b0, v); check("R8 ctrl unchanged by busy write", v, 16'h0A13);
    repeat (FLEN) @(negedge clk);
    rd_reg(1'b0, v); check("R8 ctrl after ignored write", v, 16'h8A13);
    rd_reg(1'b1, v); check("R7 read data 3C96", v, 16'h3C96);

    // junk bits masked (R9), write frame with data FFFF-bit command
    wr_reg(1'b1, 16'h0F0F);
    run_frame(16'hFFFF);
    rd_reg(1'b0, v); check("R9 junk bits masked", v, 16'hBF1F);
    rd_reg(1'b1, v); check("R10 data after write frame", v, 16'h0F0F);

    repeat (5) @(negedge clk);
    run_done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!run_done) begin
      checks++; errors++;
      $display("FAIL R2 watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule